// File: doc/BRIEF.md
# Three-Timer Sticky Status and Enable Register

This block is a 16-bit status and control word for three timers, reached over a simple synchronous register bus (select, write strobe, read strobe, write data, read data). For each timer it keeps two sticky latches and one enable flag. The first latch records an interrupt event and the second records an overflow or error event. Both are set by single-cycle pulses from the timer and stay set until software writes a one to them. Both are also driven out as signals: the interrupt latches serve as interrupt lines to the rest of the chip.

Each timer's enable is controlled by a pair of bits. A one on the lower bit of the pair switches the timer on. A one on the upper bit switches it off. If both bits carry a one in the same write, the timer is switched off. A read shows the enable state on both bits of the pair, so software can test either bit. The enables go straight to the timers. The counters and period logic live outside this block.

Top module: `tstat_reg`

## Requirements
- R1: A synchronous active-high reset clears every interrupt latch, overflow latch and enable, so every output reads zero after reset.
- R2: An interrupt event pulse for timer k sets latch bit k (bits 0, 1, 2) on the next clock edge. The latch stays set after the pulse ends and drives output `irq_o[k]`.
- R3: An overflow event pulse for timer k sets latch bit 4+k (bits 4, 5, 6) on the next clock edge. The latch stays set after the pulse ends and drives output `ovf_o[k]`.
- R4: A write with a one on a latch bit clears that latch at the next edge. A write with a zero on a latch bit leaves that latch unchanged.
- R5: If an event pulse and a write-one-to-clear reach the same latch in the same cycle, the latch stays set.
- R6: A write with a one on bit 8+2k (and a zero on bit 9+2k) sets the enable of timer k at the next edge. The enable drives `tmr_en_o[k]`.
- R7: A write with a one on bit 9+2k clears the enable of timer k at the next edge. This holds even when bit 8+2k is also one.
- R8: A read returns the enable of timer k on both bit 8+2k and bit 9+2k. It returns the latches on their own bit positions.
- R9: Bits 3, 7, 14 and 15 always read as zero. Writes to these bits change no state.
- R10: A write with zeros in every enable/disable pair leaves all enables unchanged. A write strobe without select changes no state.
- R11: `rdata` is zero whenever select and read strobe are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Address decode: register selected |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational, zero when not reading |
| irq_evt | input | 3 | Per-timer interrupt event pulses |
| ovf_evt | input | 3 | Per-timer overflow/error event pulses |
| irq_o | output | 3 | Latched interrupt lines |
| ovf_o | output | 3 | Latched overflow/error lines |
| tmr_en_o | output | 3 | Timer enables |

## Verification
Every state change (event capture, clear, enable set or clear) appears one clock edge after the cycle in which the stimulus is held. The read path has no register, so `rdata` shows the state as it stands in the same cycle as the read strobe. The bench drives stimulus on the falling edge and holds it for exactly one cycle. It samples the outputs at the next falling edge, after the single rising edge that commits the change. Reads are sampled a short delay after the strobe is raised within that same half-period, before any edge can intervene.

// File: rtl/tstat_pkg.sv
package tstat_pkg;
  localparam int NUM_TMR = 3;
  localparam int REG_W   = 16;
  localparam int IRQ_LO  = 0;
  localparam int OVF_LO  = 4;
  localparam int EN_LO   = 8;

  function automatic int f_irq_pos(input int k);
    return IRQ_LO + k;
  endfunction

  function automatic int f_ovf_pos(input int k);
    return OVF_LO + k;
  endfunction

  function automatic int f_en_pos(input int k);
    return EN_LO + 2 * k;
  endfunction

  function automatic int f_dis_pos(input int k);
    return EN_LO + 2 * k + 1;
  endfunction

  // mask of every bit that carries meaning for n timers
  function automatic logic [REG_W-1:0] f_used_mask(input int n);
    logic [REG_W-1:0] m;
    m = '0;
    for (int k = 0; k < n; k++) begin
      m[f_irq_pos(k)] = 1'b1;
      m[f_ovf_pos(k)] = 1'b1;
      m[f_en_pos(k)]  = 1'b1;
      m[f_dis_pos(k)] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/tstat_latch.sv
module tstat_latch #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) q[k] <= 1'b0;
      else     q[k] <= evt[k] | (q[k] & ~clr[k]);
    end

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
      evt[k] |=> q[k]);
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
      (q[k] && !clr[k]) |=> q[k]);
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
      (clr[k] && !evt[k]) |=> !q[k]);
    p_evt_beats_clr_r5: assert property (@(posedge clk) disable iff (rst)
      (clr[k] && evt[k]) |=> q[k]);
  end
endmodule

// File: rtl/tstat_en.sv
module tstat_en #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] en
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         en[k] <= 1'b0;
      else if (clr[k]) en[k] <= 1'b0;
      else if (set[k]) en[k] <= 1'b1;
    end

    p_set_r6: assert property (@(posedge clk) disable iff (rst)
      (set[k] && !clr[k]) |=> en[k]);
    p_dis_wins_r7: assert property (@(posedge clk) disable iff (rst)
      clr[k] |=> !en[k]);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!set[k] && !clr[k]) |=> $stable(en[k]));
    p_reset_r1: assert property (@(posedge clk)
      rst |=> !en[k]);
  end
endmodule

// File: rtl/tstat_reg.sv
module tstat_reg
  import tstat_pkg::*;
#(
  parameter int N = NUM_TMR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             wr_stb,
  input  logic             rd_stb,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic [N-1:0]     irq_evt,
  input  logic [N-1:0]     ovf_evt,
  output logic [N-1:0]     irq_o,
  output logic [N-1:0]     ovf_o,
  output logic [N-1:0]     tmr_en_o
);
  localparam logic [REG_W-1:0] USED = f_used_mask(N);

  logic             wr_fire;
  logic             rd_fire;
  logic [N-1:0]     irq_clr, ovf_clr, en_set, en_clr;
  logic [REG_W-1:0] image;
  logic [REG_W-1:0] unused_wbits;

  assign wr_fire      = sel & wr_stb;
  assign rd_fire      = sel & rd_stb;
  assign unused_wbits = wdata & ~USED;

  for (genvar k = 0; k < N; k++) begin : g_dec
    assign irq_clr[k] = wr_fire & wdata[f_irq_pos(k)];
    assign ovf_clr[k] = wr_fire & wdata[f_ovf_pos(k)];
    assign en_set[k]  = wr_fire & wdata[f_en_pos(k)];
    assign en_clr[k]  = wr_fire & wdata[f_dis_pos(k)];
  end

  tstat_latch #(.N(N)) u_irq (
    .clk(clk), .rst(rst), .evt(irq_evt), .clr(irq_clr), .q(irq_o));

  tstat_latch #(.N(N)) u_ovf (
    .clk(clk), .rst(rst), .evt(ovf_evt), .clr(ovf_clr), .q(ovf_o));

  tstat_en #(.N(N)) u_en (
    .clk(clk), .rst(rst), .set(en_set), .clr(en_clr), .en(tmr_en_o));

  always_comb begin
    image = '0;
    for (int k = 0; k < N; k++) begin
      image[f_irq_pos(k)] = irq_o[k];
      image[f_ovf_pos(k)] = ovf_o[k];
      image[f_en_pos(k)]  = tmr_en_o[k];
      image[f_dis_pos(k)] = tmr_en_o[k];
    end
  end

  assign rdata = rd_fire ? image : '0;

  p_idle_bus_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |-> (rdata == '0));
  p_nowrite_r10: assert property (@(posedge clk) disable iff (rst)
    (!wr_fire && irq_evt == '0 && ovf_evt == '0) |=>
      ($stable(irq_o) && $stable(ovf_o) && $stable(tmr_en_o)));
endmodule

// File: tb/tstat_reg_tb.sv
module tstat_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  irq_evt = '0, ovf_evt = '0;
  logic [2:0]  irq_o, ovf_o, tmr_en_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tstat_reg u_dut (
    .clk(clk), .rst(rst), .sel(sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wdata(wdata), .rdata(rdata), .irq_evt(irq_evt), .ovf_evt(ovf_evt),
    .irq_o(irq_o), .ovf_o(ovf_o), .tmr_en_o(tmr_en_o));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle bus write; state is committed at the next falling edge
  task automatic bus_wr(input logic [15:0] d, input logic s = 1'b1,
                        input logic [2:0] ie = '0, input logic [2:0] oe = '0);
    @(negedge clk);
    sel = s; wr_stb = 1'b1; wdata = d; irq_evt = ie; ovf_evt = oe;
    @(negedge clk);
    sel = 1'b0; wr_stb = 1'b0; wdata = '0; irq_evt = '0; ovf_evt = '0;
  endtask

  task automatic pulse(input logic [2:0] ie, input logic [2:0] oe);
    @(negedge clk);
    irq_evt = ie; ovf_evt = oe;
    @(negedge clk);
    irq_evt = '0; ovf_evt = '0;
  endtask

  task automatic bus_rd(output logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; rd_stb = 1'b1;
    #1 d = rdata;
    sel = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 irq", {13'd0, irq_o}, 16'h0);
    chk("R1 ovf", {13'd0, ovf_o}, 16'h0);
    chk("R1 en",  {13'd0, tmr_en_o}, 16'h0);
    bus_rd(d); chk("R1 read", d, 16'h0000);
    #1 chk("R11 idle rdata", rdata, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    pulse(3'b101, 3'b000);
    chk("R2 irq lines", {13'd0, irq_o}, 16'h0005);
    @(negedge clk);
    chk("R2 sticky", {13'd0, irq_o}, 16'h0005);
    bus_rd(d); chk("R2 read", d, 16'h0005);
  endtask

  task automatic t_ovf();
    logic [15:0] d;
    pulse(3'b000, 3'b010);
    chk("R3 ovf lines", {13'd0, ovf_o}, 16'h0002);
    bus_rd(d); chk("R3 read", d, 16'h0025);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    bus_wr(16'h0001);
    bus_rd(d); chk("R4 clear irq0 only", d, 16'h0024);
    bus_wr(16'h0020);
    bus_rd(d); chk("R4 clear ovf1", d, 16'h0004);
    bus_wr(16'h0000);
    bus_rd(d); chk("R4 zero keeps", d, 16'h0004);
  endtask

  task automatic t_race();
    logic [15:0] d;
    bus_wr(16'h0044, 1'b1, 3'b100, 3'b100);
    bus_rd(d); chk("R5 event wins", d, 16'h0044);
    bus_wr(16'h0044);
    bus_rd(d); chk("R4 clear after race", d, 16'h0000);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    bus_wr(16'h1100);
    chk("R6 enables", {13'd0, tmr_en_o}, 16'h0005);
    bus_rd(d); chk("R8 pair readback", d, 16'h3300);
    bus_wr(16'h0200);
    chk("R7 disable t0", {13'd0, tmr_en_o}, 16'h0004);
    bus_wr(16'h0C00);
    chk("R7 both bits clear t1 off", {13'd0, tmr_en_o}, 16'h0004);
    bus_wr(16'h0400);
    bus_wr(16'h0C00);
    chk("R7 both clears set t1", {13'd0, tmr_en_o}, 16'h0004);
  endtask

  task automatic t_hold();
    logic [15:0] d;
    bus_wr(16'h0400);
    bus_wr(16'h0077);
    chk("R10 pairs zero keep", {13'd0, tmr_en_o}, 16'h0006);
    bus_wr(16'h2A00, 1'b0);
    chk("R10 no sel no effect", {13'd0, tmr_en_o}, 16'h0006);
    bus_rd(d); chk("R8 readback t1 t2", d, 16'h3C00);
  endtask

  task automatic t_rsvd();
    logic [15:0] d;
    bus_wr(16'hC088);
    bus_rd(d); chk("R9 reserved writes ignored", d, 16'h3C00);
    pulse(3'b111, 3'b111);
    bus_rd(d); chk("R9 reserved read zero", d & 16'hC088, 16'h0000);
    chk("R8 full image", d, 16'h3C77);
    #1 chk("R11 rdata idle", rdata, 16'h0000);
  endtask

  initial begin
    fork
      begin
        @(negedge clk); @(negedge clk);
        t_reset(); t_irq(); t_ovf(); t_w1c(); t_race();
        t_enable(); t_hold(); t_rsvd(); t_reset();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++; failures++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule